// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Least-Recently-Used Replacement

This block sits between a requester and a slower word-wide memory. A byte address is split into a tag, a set number, a word-in-line number and a byte-in-word number. The set number picks one set, and the tags of both ways of that set are compared at the same time. A match returns the stored word one cycle after the request is taken. A miss holds off the requester while a whole four-word line is read from memory into a way of the set. When both ways hold data, the way chosen is the one used less recently. Otherwise it is an empty way. The access then completes on the cycle after the last word of the line arrives.

Stores use write-through. Every store, hit or miss, is sent to memory in the cycle its response appears. A store that hits changes the cached word in place. A store that misses first brings in the line and merges the new word into it while the line is being filled. Each set keeps a single bit that points at its replacement candidate. Every hit and every fill in that set points this bit at the other way.

Top module: `cache2w_top`

## Requirements
- R1: With 32-bit words and four-word lines, address bits [3:2] select the word in the line. The next log2(NUM_SETS) bits select the set, and all remaining upper bits form the tag. A memory line read is issued at the line's base address, whose low four bits are zero.
- R2: A load that matches a valid tag in either way of its set gives `rsp_valid` with `rsp_hit`=1 and the stored word in the cycle after it is accepted. It starts no memory read.
- R3: A miss starts exactly one memory line read, and `req_ready` stays low from the cycle after acceptance until the response.
- R4: A missed access completes in the cycle after the fourth read beat is received, with `rsp_hit`=0. For a load, `rsp_rdata` is the memory word at the requested word offset.
- R5: Two lines with different tags that map to the same set are both kept, one per way. An empty way is filled before any valid line is displaced, and a line is never present in both ways of a set.
- R6: When both ways of a set are valid, a miss replaces the way that was not the most recent one to hit or be filled in that set.
- R7: A store that hits updates the cached word, so later loads see the new value. In its response cycle it drives `mem_wr_en` with the same address and data. `rsp_rdata` echoes the stored word.
- R8: A store that misses fills the line from memory, merges the store data into it, and writes the word to memory in its response cycle. Later loads hit on both the stored word and the rest of the line.
- R9: After reset, every line is invalid, `req_ready` is 1 and `rsp_valid` is 0. The first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit | output | 1 | Response was a hit |
| rsp_rdata | output | DATA_W | Load data, or echoed store data |
| mem_rd_req | output | 1 | One-cycle line read request |
| mem_rd_addr | output | ADDR_W | Line base address of the read |
| mem_rd_valid | input | 1 | Read beat present, four beats in word order |
| mem_rd_data | input | DATA_W | Read beat data |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through byte address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The bench builds the cache with NUM_SETS=4. With that value, addresses 64 bytes apart land in the same set with different tags, so a short list of addresses is enough to fill both ways, force LRU evictions, and bring back evicted lines. The memory model answers a line read three cycles after the request, so a miss takes a fixed ten cycles from acceptance to response. The bench checks that exact count against the cycle-after-last-beat rule. The model also applies write-through stores to its own copy of memory, so every load result can be compared with that copy.

// File: rtl/cache2w_pkg.sv
// Shared types for the two-way cache.
// Assumes: a single outstanding request; the controller owns all sequencing.
package cache2w_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,    // accepting requests, lookup is combinational
        ST_REQ,     // line read request is on the memory port
        ST_FILL     // collecting line beats into the victim way
    } cstate_t;
endpackage

// File: rtl/cache2w_way.sv
// One way of the cache: valid bits, tags and line data for every set.
// Does: parallel tag compare on the lookup set, word read-out, word and tag
// writes. Assumes: writer never updates a tag and looks it up in one cycle.
module cache2w_way #(
    parameter int NUM_SETS   = 64,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32,
    parameter int SET_W      = 6,
    parameter int OFF_W      = 2,
    parameter int TAG_W      = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  lk_set,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [OFF_W-1:0]  lk_off,
    output logic              hit,
    output logic              valid,
    output logic [DATA_W-1:0] word,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_en,
    input  logic [TAG_W-1:0]  tag_in
);
    logic [DATA_W-1:0] data_q [NUM_SETS][LINE_WORDS];
    logic [TAG_W-1:0]  tag_q  [NUM_SETS];
    logic [NUM_SETS-1:0] valid_q;

    // Lookup: valid and tag match on the selected set, word mux by offset.
    assign valid = valid_q[lk_set];
    assign hit   = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
    assign word  = data_q[lk_set][lk_off];

    // Storage write for data words and tags (no reset on arrays).
    always_ff @(posedge clk) begin
        if (wr_en)  data_q[wr_set][wr_off] <= wr_data;
        if (tag_en) tag_q[wr_set]          <= tag_in;
    end

    // Valid bits: cleared by reset, set when a line's tag is installed.
    always_ff @(posedge clk) begin
        if (!rst_n)      valid_q         <= '0;
        else if (tag_en) valid_q[wr_set] <= 1'b1;
    end
endmodule

// File: rtl/cache2w_lru.sv
// Per-set replacement bit and victim choice.
// Does: victim = empty way 0, else empty way 1, else the way the bit names.
// Assumes: upd_way is the way just used; the bit then names the other way.
module cache2w_lru #(
    parameter int NUM_SETS = 64,
    parameter int SET_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [1:0]       lk_valid,
    output logic             victim,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic             upd_way
);
    logic [NUM_SETS-1:0] repl_q;

    // Victim choice: invalid ways before the least recently used one.
    always_comb begin
        if (!lk_valid[0])      victim = 1'b0;
        else if (!lk_valid[1]) victim = 1'b1;
        else                   victim = repl_q[lk_set];
    end

    // Replacement bit update: point away from the way just used.
    always_ff @(posedge clk) begin
        if (!rst_n)      repl_q          <= '0;
        else if (upd_en) repl_q[upd_set] <= ~upd_way;
    end
endmodule

// File: rtl/cache2w_top.sv
// Two-way set-associative write-through cache, four-word lines.
// Does: lookup, hit response, miss refill from a beat-per-word memory port,
// write-allocate merge, write-through strobe. Assumes memory accepts a write
// strobe every cycle and returns LINE_WORDS beats in word order after a read.
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_SETS   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int OFF_W    = $clog2(LINE_WORDS);
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int LINE_LSB = BYTE_W + OFF_W;
    localparam int TAG_W    = ADDR_W - SET_W - LINE_LSB;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    cstate_t            state_q;
    logic [ADDR_W-1:0]  sv_addr;
    logic               sv_write;
    logic [DATA_W-1:0]  sv_wdata;
    logic               sv_way;
    logic [OFF_W-1:0]   beat_q;
    logic               rsp_valid_q, rsp_hit_q, mem_wr_en_q;
    logic [DATA_W-1:0]  rsp_rdata_q, mem_wr_data_q;
    logic [ADDR_W-1:0]  mem_wr_addr_q;

    logic [TAG_W-1:0]   lk_tag, sv_tag;
    logic [SET_W-1:0]   lk_set, sv_set;
    logic [OFF_W-1:0]   lk_off, sv_off;
    logic [NUM_WAYS-1:0] way_hit, way_valid, w_we, t_we;
    logic [NUM_WAYS-1:0][DATA_W-1:0] way_word;
    logic [SET_W-1:0]   w_set;
    logic [OFF_W-1:0]   w_off;
    logic [DATA_W-1:0]  w_data, merged;
    logic               accept, hit_any, hit_way, fill_beat, last_beat, victim;
    logic               upd_en, upd_way;
    logic [SET_W-1:0]   upd_set;

    // Address fields of the live request and of the held miss.
    assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign lk_set = req_addr[LINE_LSB +: SET_W];
    assign lk_off = req_addr[BYTE_W +: OFF_W];
    assign sv_tag = sv_addr[ADDR_W-1 -: TAG_W];
    assign sv_set = sv_addr[LINE_LSB +: SET_W];
    assign sv_off = sv_addr[BYTE_W +: OFF_W];

    // Handshake and hit resolution; way 0 wins if both ever matched.
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit_any   = |way_hit;
    assign hit_way   = way_hit[0] ? 1'b0 : 1'b1;
    assign fill_beat = (state_q == ST_FILL) && mem_rd_valid;
    assign last_beat = fill_beat && (beat_q == LAST_BEAT);
    assign merged    = (sv_write && beat_q == sv_off) ? sv_wdata : mem_rd_data;

    // Array write steering: store hit in place, or refill beat into victim.
    always_comb begin
        w_we   = '0;
        t_we   = '0;
        w_set  = lk_set;
        w_off  = lk_off;
        w_data = req_wdata;
        if (accept && req_write && hit_any) begin
            w_we[hit_way] = 1'b1;
        end else if (fill_beat) begin
            w_we[sv_way] = 1'b1;
            t_we[sv_way] = last_beat;
            w_set        = sv_set;
            w_off        = beat_q;
            w_data       = merged;
        end
    end

    // Both ways, compared in parallel.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        cache2w_way #(
            .NUM_SETS(NUM_SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W),
            .SET_W(SET_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
        ) u_way (
            .clk(clk), .rst_n(rst_n),
            .lk_set(lk_set), .lk_tag(lk_tag), .lk_off(lk_off),
            .hit(way_hit[g]), .valid(way_valid[g]), .word(way_word[g]),
            .wr_en(w_we[g]), .wr_set(w_set), .wr_off(w_off), .wr_data(w_data),
            .tag_en(t_we[g]), .tag_in(sv_tag)
        );
    end

    // Replacement state update on every hit and on line completion.
    assign upd_en  = (accept && hit_any) || last_beat;
    assign upd_set = last_beat ? sv_set : lk_set;
    assign upd_way = last_beat ? sv_way : hit_way;

    cache2w_lru #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_valid(way_valid), .victim(victim),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way)
    );

    // Controller: hit response, miss capture, beat counting, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            beat_q      <= '0;
            rsp_valid_q <= 1'b0;
            mem_wr_en_q <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            mem_wr_en_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    sv_addr  <= req_addr;
                    sv_write <= req_write;
                    sv_wdata <= req_wdata;
                    if (hit_any) begin
                        rsp_valid_q   <= 1'b1;
                        rsp_hit_q     <= 1'b1;
                        rsp_rdata_q   <= req_write ? req_wdata : way_word[hit_way];
                        mem_wr_en_q   <= req_write;
                        mem_wr_addr_q <= req_addr;
                        mem_wr_data_q <= req_wdata;
                    end else begin
                        sv_way  <= victim;
                        beat_q  <= '0;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: state_q <= ST_FILL;
                ST_FILL: if (mem_rd_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == sv_off) rsp_rdata_q <= merged;
                    if (beat_q == LAST_BEAT) begin
                        state_q       <= ST_IDLE;
                        rsp_valid_q   <= 1'b1;
                        rsp_hit_q     <= 1'b0;
                        mem_wr_en_q   <= sv_write;
                        mem_wr_addr_q <= sv_addr;
                        mem_wr_data_q <= sv_wdata;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_req  = (state_q == ST_REQ);
    assign mem_rd_addr = {sv_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
    assign rsp_valid   = rsp_valid_q;
    assign rsp_hit     = rsp_hit_q;
    assign rsp_rdata   = rsp_rdata_q;
    assign mem_wr_en   = mem_wr_en_q;
    assign mem_wr_addr = mem_wr_addr_q;
    assign mem_wr_data = mem_wr_data_q;
endmodule

// File: rtl/cache2w_chk.sv
// Protocol checker for cache2w_top, attached by bind.
// Assumes: way_hit is the per-way compare result inside the top.
module cache2w_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       mem_rd_req,
    input logic       mem_rd_valid,
    input logic       mem_wr_en,
    input logic [1:0] way_hit
);
    // R2
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (way_hit != 2'b00)) |=> (rsp_valid && rsp_hit));

    // R3
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !req_ready);

    // R4
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> $past(mem_rd_valid));

    // R5
    single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R7
    wr_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> rsp_valid);
endmodule

bind cache2w_top cache2w_chk u_cache2w_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .mem_rd_req(mem_rd_req),
    .mem_rd_valid(mem_rd_valid), .mem_wr_en(mem_wr_en), .way_hit(way_hit)
);

// File: tb/test_cache2w_top.sv
// Directed bench for cache2w_top with four sets and a fixed-latency memory.
module test_cache2w_top;
    localparam int MISS_LAT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_hit;
    logic [31:0] rsp_rdata;
    logic        mem_rd_req, mem_rd_valid, mem_wr_en;
    logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    cache2w_top #(.NUM_SETS(4)) i_cache2w_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Memory model: 256 words, 3-cycle delay, then four beats in order.
    logic [31:0] model [256];
    logic        busy;
    logic [1:0]  lat;
    logic [7:0]  base;
    logic [1:0]  beat;
    int          rd_count;
    logic [31:0] last_rd_addr;

    function automatic logic [31:0] initval(int i);
        return (32'(i) * 32'h0001_0001) ^ 32'hC0DE_0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
            rd_count <= 0; last_rd_addr <= '0; lat <= '0; base <= '0; beat <= '0;
            for (int i = 0; i < 256; i++) model[i] <= initval(i);
        end else begin
            mem_rd_valid <= 1'b0;
            if (mem_rd_req) begin
                busy <= 1'b1; lat <= 2'd3; beat <= '0;
                base <= mem_rd_addr[9:2];
                rd_count <= rd_count + 1;
                last_rd_addr <= mem_rd_addr;
            end else if (busy) begin
                if (lat != 0) lat <= lat - 1'b1;
                else begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= model[base + 8'(beat)];
                    beat <= beat + 1'b1;
                    if (beat == 2'd3) busy <= 1'b0;
                end
            end
            if (mem_wr_en) model[mem_wr_addr[9:2]] <= mem_wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access; returns hit flag, data and cycles from acceptance to response.
    task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                          output bit hit, output logic [31:0] rd, output int cyc);
        bit stall_ok = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 50) begin
            if (req_ready) stall_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        hit = rsp_hit;
        rd  = rsp_rdata;
        check(stall_ok, "R3 ready low while waiting", 32'(stall_ok), 32'd1);
    endtask

    task automatic t_reset();
        bit h; logic [31:0] d; int c, n0;
        check(req_ready === 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0, "R9 no response after reset", 32'(rsp_valid), 32'd0);
        n0 = rd_count;
        access(1'b0, 32'h0000_0014, '0, h, d, c);
        check(h == 1'b0, "R9 first access misses", 32'(h), 32'd0);
        check(rd_count == n0 + 1, "R3 one line read", 32'(rd_count), 32'(n0 + 1));
        check(last_rd_addr == 32'h0000_0010, "R1 line-aligned read address",
              last_rd_addr, 32'h0000_0010);
        check(c == MISS_LAT, "R4 completes after last beat", 32'(c), 32'(MISS_LAT));
        check(d == model[5], "R4 miss data at word offset", d, model[5]);
    endtask

    task automatic t_hit();
        bit h; logic [31:0] d; int c, n0;
        n0 = rd_count;
        access(1'b0, 32'h0000_001C, '0, h, d, c);
        check(h && c == 1, "R2 hit in next cycle", {31'(c), h}, {31'd1, 1'b1});
        check(d == model[7], "R1 word offset selects word", d, model[7]);
        check(rd_count == n0, "R2 no memory read on hit", 32'(rd_count), 32'(n0));
    endtask

    task automatic t_two_ways();
        bit h; logic [31:0] d; int c;
        access(1'b0, 32'h0000_0050, '0, h, d, c);
        check(!h, "R5 other tag same set misses", 32'(h), 32'd0);
        check(d == model[20], "R4 second line data", d, model[20]);
        access(1'b0, 32'h0000_0010, '0, h, d, c);
        check(h, "R5 first line kept", 32'(h), 32'd1);
        access(1'b0, 32'h0000_0058, '0, h, d, c);
        check(h && d == model[22], "R5 second line kept", d, model[22]);
    endtask

    task automatic t_lru();
        bit h; logic [31:0] d; int c;
        // MRU is the 0x50 line; 0x90 must evict the 0x10 line.
        access(1'b0, 32'h0000_0090, '0, h, d, c);
        check(!h && d == model[36], "R6 new line fills", d, model[36]);
        access(1'b0, 32'h0000_0054, '0, h, d, c);
        check(h, "R6 recently used line survives", 32'(h), 32'd1);
        access(1'b0, 32'h0000_0010, '0, h, d, c);
        check(!h, "R6 least recently used line evicted", 32'(h), 32'd0);
        access(1'b0, 32'h0000_0050, '0, h, d, c);
        check(h, "R6 line used before the fill retained", 32'(h), 32'd1);
        access(1'b0, 32'h0000_0090, '0, h, d, c);
        check(!h, "R6 older line evicted", 32'(h), 32'd0);
    endtask

    task automatic t_write_hit();
        bit h; logic [31:0] d; int c;
        access(1'b0, 32'h0000_0020, '0, h, d, c);
        access(1'b1, 32'h0000_0024, 32'hDEAD_BEEF, h, d, c);
        check(h && c == 1, "R7 store hit response", {31'(c), h}, {31'd1, 1'b1});
        check(d == 32'hDEAD_BEEF, "R7 store echo", d, 32'hDEAD_BEEF);
        @(negedge clk);
        check(model[9] == 32'hDEAD_BEEF, "R7 write-through reached memory",
              model[9], 32'hDEAD_BEEF);
        access(1'b0, 32'h0000_0024, '0, h, d, c);
        check(h && d == 32'hDEAD_BEEF, "R7 cached word updated", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_write_miss();
        bit h; logic [31:0] d; int c, n0;
        logic [31:0] side;
        n0 = rd_count;
        side = model[13];
        access(1'b1, 32'h0000_0038, 32'h1234_5678, h, d, c);
        check(!h && c == MISS_LAT, "R8 store miss fills", {31'(c), h}, {31'(MISS_LAT), 1'b0});
        check(rd_count == n0 + 1, "R8 one line read", 32'(rd_count), 32'(n0 + 1));
        @(negedge clk);
        check(model[14] == 32'h1234_5678, "R8 write-through reached memory",
              model[14], 32'h1234_5678);
        access(1'b0, 32'h0000_0038, '0, h, d, c);
        check(h && d == 32'h1234_5678, "R8 merged word hits", d, 32'h1234_5678);
        access(1'b0, 32'h0000_0034, '0, h, d, c);
        check(h && d == side, "R8 rest of line hits", d, side);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_two_ways();
        t_lru();
        t_write_hit();
        t_write_miss();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule